// File: doc/BRIEF.md
# Machine-Mode Control and Status Register File

This block holds the 32-bit machine-level control and status registers of a small RISC-V core. A 12-bit register address selects one of thirteen supported registers. The read data and an illegal-address flag follow the address combinationally. A write strobe with write data updates the selected register on the next rising clock edge. Each register applies its own fixed writable-bit mask, so bits outside the mask keep their stored value.

Two counters run on their own. The machine cycle counter advances on each clock in which an instruction fetch is reported. The instructions-retired counter advances on each clock in which a retirement is reported. A user-visible cycle shadow register follows the machine cycle counter at every update, including software writes. On a trap, dedicated inputs load the exception PC and the cause register in a single clock.

The interface has no stream of data passing through it: every pin is a plain control or status pin. An access completes in one cycle, so there is no valid/ready handshake and the block never stalls its caller.

Top module: `mcsr_file`

## Requirements
- R1: The addresses 0x300, 0x301, 0x304, 0x305, 0x340, 0x341, 0x342, 0x343, 0x344, 0x34A, 0x34B, 0xB00 and 0xB02 each select one register (status, ISA, interrupt enable, trap vector, scratch, exception PC, cause, trap value, interrupt pending, trap instruction, second trap value, machine cycle, instructions retired). Read data follows the address in the same cycle. A write with the strobe high takes effect at the next rising edge.
- R2: A write to the status register (0x300) changes only the bits set in 0x807FFFEA. Every other bit keeps its previous value.
- R3: The ISA register (0x301) always reads 0x40001100, and writes to it have no effect.
- R4: A write to interrupt enable (0x304) changes only the bits in 0x00FF0AAA. A write to interrupt pending (0x344) changes only the bits in 0x00000222.
- R5: The machine cycle counter (0xB00) increases by one, modulo 2^32, at each rising edge where `fetch_valid` is high.
- R6: A write to the machine cycle counter loads the value into the counter and into `cycle_shadow` at the same edge. After every edge, `cycle_shadow` equals the machine cycle counter.
- R7: After reset, every register reads zero except the ISA register, which reads 0x40001100.
- R8: If a write to the machine cycle counter and `fetch_valid` occur in the same cycle, the written value is loaded and the increment is dropped.
- R9: An address outside the R1 list raises `csr_illegal` and reads zero. A write to such an address changes no register.
- R10: With `trap_valid` high, the next edge loads the exception PC from `trap_pc` and the cause from `trap_cause`. This takes priority over a software write to either register in the same cycle.
- R11: The instructions-retired counter (0xB02) increases by one at each edge where `retire_valid` is high. A software write loads all 32 bits and takes priority over the increment.
- R12: The trap vector, scratch, trap value, trap instruction and second trap value registers accept all 32 bits on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_addr | input | 12 | Register address for read and write |
| csr_wr_en | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data of the addressed register |
| csr_illegal | output | 1 | Address is not a supported register |
| fetch_valid | input | 1 | One instruction fetch this cycle |
| retire_valid | input | 1 | One instruction retired this cycle |
| trap_valid | input | 1 | Trap entry this cycle |
| trap_pc | input | 32 | PC to store on trap entry |
| trap_cause | input | 32 | Cause code to store on trap entry |
| cycle_shadow | output | 32 | User cycle shadow of the machine cycle counter |

## Verification
Read data and the illegal flag are combinational in the address. The bench sets the address on a falling edge and compares one time step later, with no clock edge in between. Writes, trap entries and counter increments land at the next rising edge. Each stimulus is therefore driven on a falling edge and held for exactly one rising edge before the value is read back. For counting runs, `fetch_valid` or `retire_valid` is held for N rising edges and the counter is expected to move by exactly N. `cycle_shadow` is checked in the same falling-edge window as the counter it mirrors.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 12;
  localparam int NUM_CSR = 13;

  localparam int IDX_MSTATUS = 0;
  localparam int IDX_MISA    = 1;
  localparam int IDX_MIE     = 2;
  localparam int IDX_MEPC    = 5;
  localparam int IDX_MCAUSE  = 6;
  localparam int IDX_MIP     = 8;
  localparam int IDX_MCYCLE  = 11;
  localparam int IDX_MINSTRET = 12;

  localparam logic [DATA_W-1:0] ISA_VALUE = 32'h4000_1100;

  typedef enum logic [1:0] {
    KIND_RW,
    KIND_CONST,
    KIND_COUNT,
    KIND_TRAP
  } csr_kind_e;

  function automatic logic [ADDR_W-1:0] csr_addr_of(int idx);
    case (idx)
      0:  return 12'h300;
      1:  return 12'h301;
      2:  return 12'h304;
      3:  return 12'h305;
      4:  return 12'h340;
      5:  return 12'h341;
      6:  return 12'h342;
      7:  return 12'h343;
      8:  return 12'h344;
      9:  return 12'h34A;
      10: return 12'h34B;
      11: return 12'hB00;
      default: return 12'hB02;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] csr_mask_of(int idx);
    case (idx)
      IDX_MSTATUS: return 32'h807F_FFEA;
      IDX_MISA:    return 32'h0000_0000;
      IDX_MIE:     return 32'h00FF_0AAA;
      IDX_MIP:     return 32'h0000_0222;
      default:     return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic csr_kind_e csr_kind_of(int idx);
    case (idx)
      IDX_MISA:                return KIND_CONST;
      IDX_MCYCLE, IDX_MINSTRET: return KIND_COUNT;
      IDX_MEPC, IDX_MCAUSE:    return KIND_TRAP;
      default:                 return KIND_RW;
    endcase
  endfunction
endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
  import mcsr_pkg::*;
#(
  parameter int N  = NUM_CSR,
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  hit,
  output logic          illegal
);
  for (genvar i = 0; i < N; i++) begin : g_match
    assign hit[i] = (addr == csr_addr_of(i));
  end
  assign illegal = ~|hit;
endmodule

// File: rtl/mcsr_field_reg.sv
module mcsr_field_reg #(
  parameter int             W    = 32,
  parameter logic [W-1:0]   MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= (q & ~MASK) | (wdata & MASK);
  end

  // R2 / R4: bits outside the writable mask never move
  a_r2_r4_ro_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((q & ~MASK) == ($past(q) & ~MASK)));
  // R1: no strobe, no change
  a_r1_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/mcsr_counter.sv
module mcsr_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (inc)  q <= q + 1'b1;
  end

  // R5 / R11: one step per qualifying cycle
  a_r5_r11_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> (q == $past(q) + 1'b1));
  // R8: a load wins over the increment
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(load_val)));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(q));
endmodule

// File: rtl/mcsr_file.sv
module mcsr_file
  import mcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              csr_wr_en,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              csr_illegal,
  input  logic              fetch_valid,
  input  logic              retire_valid,
  input  logic              trap_valid,
  input  logic [DATA_W-1:0] trap_pc,
  input  logic [DATA_W-1:0] trap_cause,
  output logic [DATA_W-1:0] cycle_shadow
);
  logic [NUM_CSR-1:0]             hit;
  logic [NUM_CSR-1:0][DATA_W-1:0] regval;

  mcsr_decode #(.N(NUM_CSR), .AW(ADDR_W)) u_decode (
    .addr    (csr_addr),
    .hit     (hit),
    .illegal (csr_illegal)
  );

  for (genvar i = 0; i < NUM_CSR; i++) begin : g_csr
    if (csr_kind_of(i) == KIND_CONST) begin : g_const
      assign regval[i] = ISA_VALUE;
    end else if (csr_kind_of(i) == KIND_COUNT) begin : g_count
      logic cnt_inc;
      assign cnt_inc = (i == IDX_MCYCLE) ? fetch_valid : retire_valid;
      mcsr_counter #(.W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (csr_wr_en & hit[i]),
        .load_val (csr_wdata),
        .inc      (cnt_inc),
        .q        (regval[i])
      );
    end else if (csr_kind_of(i) == KIND_TRAP) begin : g_trap
      logic [DATA_W-1:0] trap_val;
      assign trap_val = (i == IDX_MEPC) ? trap_pc : trap_cause;
      mcsr_field_reg #(.W(DATA_W), .MASK(csr_mask_of(i))) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (trap_valid | (csr_wr_en & hit[i])),
        .wdata (trap_valid ? trap_val : csr_wdata),
        .q     (regval[i])
      );
    end else begin : g_rw
      mcsr_field_reg #(.W(DATA_W), .MASK(csr_mask_of(i))) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (csr_wr_en & hit[i]),
        .wdata (csr_wdata),
        .q     (regval[i])
      );
    end
  end

  // Cycle shadow: updated only alongside the machine cycle counter
  logic              cyc_upd;
  logic [DATA_W-1:0] cyc_nxt;
  assign cyc_upd = (csr_wr_en & hit[IDX_MCYCLE]) | fetch_valid;
  assign cyc_nxt = (csr_wr_en & hit[IDX_MCYCLE]) ? csr_wdata
                                                 : regval[IDX_MCYCLE] + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cycle_shadow <= '0;
    else if (cyc_upd) cycle_shadow <= cyc_nxt;
  end

  always_comb begin
    csr_rdata = '0;
    for (int i = 0; i < NUM_CSR; i++) begin
      if (hit[i]) csr_rdata = csr_rdata | regval[i];
    end
  end

  // R1: at most one register selected
  a_r1_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
  // R9: unsupported address reads as zero
  a_r9_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (csr_rdata == '0));
  // R3: ISA register constant
  a_r3_isa_const: assert property (@(posedge clk) disable iff (!rst_n)
    hit[IDX_MISA] |-> (csr_rdata == ISA_VALUE));
  // R6: shadow tracks the counter
  a_r6_shadow_eq: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_shadow == regval[IDX_MCYCLE]);
  // R10: trap entry loads both registers
  a_r10_trap_load: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (regval[IDX_MEPC] == $past(trap_pc)) &&
                   (regval[IDX_MCAUSE] == $past(trap_cause)));
endmodule

// File: tb/mcsr_file_tb_top.sv
module mcsr_file_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr = 12'h000;
  logic        csr_wr_en = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_illegal;
  logic        fetch_valid = 1'b0;
  logic        retire_valid = 1'b0;
  logic        trap_valid = 1'b0;
  logic [31:0] trap_pc = '0;
  logic [31:0] trap_cause = '0;
  logic [31:0] cycle_shadow;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_val [13];

  always #10 clk = ~clk;

  mcsr_file dut_i (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr_en(csr_wr_en),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
    .fetch_valid(fetch_valid), .retire_valid(retire_valid),
    .trap_valid(trap_valid), .trap_pc(trap_pc), .trap_cause(trap_cause),
    .cycle_shadow(cycle_shadow)
  );

  function automatic logic [11:0] addr_at(int k);
    logic [11:0] t [13] = '{12'h300, 12'h301, 12'h304, 12'h305, 12'h340,
                            12'h341, 12'h342, 12'h343, 12'h344, 12'h34A,
                            12'h34B, 12'hB00, 12'hB02};
    return t[k];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_chk(int k, string req);
    csr_addr = addr_at(k);
    #1;
    check(req, csr_rdata, exp_val[k]);
    check(req, {31'd0, csr_illegal}, 32'd0);
  endtask

  task automatic do_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_wr_en = 1'b1;
    @(negedge clk);
    csr_wr_en = 1'b0;
  endtask

  task automatic t_reset;
    for (int k = 0; k < 13; k++) exp_val[k] = (k == 1) ? 32'h4000_1100 : 32'h0;
    @(negedge clk);
    for (int k = 0; k < 13; k++) read_chk(k, "R7");
    check("R7", cycle_shadow, 32'h0);
  endtask

  task automatic t_masks;
    do_write(12'h300, 32'hFFFF_FFFF); exp_val[0] = 32'h807F_FFEA; read_chk(0, "R2");
    do_write(12'h300, 32'h1234_5678); exp_val[0] = 32'h1234_5678 & 32'h807F_FFEA; read_chk(0, "R2");
    do_write(12'h304, 32'hFFFF_FFFF); exp_val[2] = 32'h00FF_0AAA; read_chk(2, "R4");
    do_write(12'h344, 32'hFFFF_FFFF); exp_val[8] = 32'h0000_0222; read_chk(8, "R4");
    do_write(12'h344, 32'h0000_0000); exp_val[8] = 32'h0; read_chk(8, "R4");
  endtask

  task automatic t_isa;
    do_write(12'h301, 32'h0000_0000); read_chk(1, "R3");
    do_write(12'h301, 32'hFFFF_FFFF); read_chk(1, "R3");
  endtask

  task automatic t_full_rw;
    for (int k = 3; k <= 10; k++) begin
      if (k == 5 || k == 6 || k == 8) continue;
      do_write(addr_at(k), 32'hA5C3_0F00 ^ k);
      exp_val[k] = 32'hA5C3_0F00 ^ k;
      read_chk(k, "R12");
    end
    do_write(12'h341, 32'h0000_1234); exp_val[5] = 32'h0000_1234; read_chk(5, "R1");
  endtask

  task automatic t_fetch_count;
    @(negedge clk);
    fetch_valid = 1'b1;
    repeat (5) @(negedge clk);
    fetch_valid = 1'b0;
    exp_val[11] = exp_val[11] + 5;
    read_chk(11, "R5");
    check("R6", cycle_shadow, exp_val[11]);
  endtask

  task automatic t_cycle_write;
    @(negedge clk);
    csr_addr = 12'hB00; csr_wdata = 32'h0000_0100; csr_wr_en = 1'b1; fetch_valid = 1'b1;
    @(negedge clk);
    csr_wr_en = 1'b0; fetch_valid = 1'b0;
    exp_val[11] = 32'h0000_0100;
    read_chk(11, "R8");
    check("R6", cycle_shadow, 32'h0000_0100);
    do_write(12'hB00, 32'hFFFF_FFFF);
    exp_val[11] = 32'hFFFF_FFFF;
    check("R6", cycle_shadow, 32'hFFFF_FFFF);
    @(negedge clk); fetch_valid = 1'b1;
    @(negedge clk); fetch_valid = 1'b0;
    exp_val[11] = 32'h0;
    read_chk(11, "R5");
    check("R6", cycle_shadow, 32'h0);
  endtask

  task automatic t_retire;
    @(negedge clk); retire_valid = 1'b1;
    repeat (3) @(negedge clk); retire_valid = 1'b0;
    exp_val[12] = 32'd3; read_chk(12, "R11");
    @(negedge clk);
    csr_addr = 12'hB02; csr_wdata = 32'hDEAD_BEEF; csr_wr_en = 1'b1; retire_valid = 1'b1;
    @(negedge clk);
    csr_wr_en = 1'b0; retire_valid = 1'b0;
    exp_val[12] = 32'hDEAD_BEEF; read_chk(12, "R11");
  endtask

  task automatic t_trap;
    @(negedge clk);
    csr_addr = 12'h341; csr_wdata = 32'h1111_1111; csr_wr_en = 1'b1;
    trap_valid = 1'b1; trap_pc = 32'h0000_0240; trap_cause = 32'h0000_0003;
    @(negedge clk);
    csr_wr_en = 1'b0; trap_valid = 1'b0;
    exp_val[5] = 32'h0000_0240; exp_val[6] = 32'h0000_0003;
    read_chk(5, "R10");
    read_chk(6, "R10");
  endtask

  task automatic t_illegal;
    @(negedge clk);
    csr_addr = 12'h7C0; #1;
    check("R9", {31'd0, csr_illegal}, 32'd1);
    check("R9", csr_rdata, 32'h0);
    do_write(12'h302, 32'hFFFF_FFFF);
    for (int k = 0; k < 13; k++) read_chk(k, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masks();
    t_isa();
    t_full_rw();
    t_fetch_count();
    t_cycle_write();
    t_retire();
    t_trap();
    t_illegal();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4000000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule